// File: doc/BRIEF.md
# Interrupt Request Capture Register

This block takes a bank of asynchronous device interrupt request lines and turns them into a stable, clock-aligned request vector for a sequencing controller. Each line first passes through a multi-flop synchroniser. The line then reaches a capture cell that ends in the output flop, and the flop drives the request vector.

One mode input governs the whole bank. In catch mode, every cell is sticky: a request seen for a single clock sets its bit. The bit then holds until software or microcode acknowledges it through that line's clear input. In level mode, the sticky path is bypassed. Each output bit then tracks its synchronised request with one clock of delay, and the clear inputs are ignored. This suits devices that hold their line until they are serviced.

An any-request output is the OR of all registered bits. The controller tests it as a single condition before it scans or encodes the vector.

Top module: `irq_capture_reg`

## Requirements
- R1: While `rst_i` is high at a rising edge, every synchroniser flop and every output bit is cleared, so `req_o` and `any_o` read 0 after that edge whatever `req_i` holds.
- R2: A change on `req_i[k]` reaches the capture cell after SYNC_STAGES rising edges (2 by default). The earliest it can appear on `req_o[k]` is after SYNC_STAGES+1 edges.
- R3: In catch mode (`mode_i` = 0), a set bit of `req_o` stays set while its clear input is low, even after the request input falls.
- R4: In catch mode, a set bit falls at the edge where its clear input is high and its synchronised request is low.
- R5: In catch mode, when a synchronised request and the clear for the same line are both high at one edge, the bit is set after that edge.
- R6: In level mode (`mode_i` = 1), each bit of `req_o` equals its synchronised request from the previous edge, and `ack_clr_i` has no effect.
- R7: `any_o` is 1 exactly when at least one bit of `req_o` is 1.
- R8: A clear on one line leaves the other lines' bits unchanged.
- R9: In catch mode, a request held high for one clock period only is still caught and stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | 0 = sticky catch mode, 1 = level pass-through mode |
| req_i | input | LINES | Raw device request lines, asynchronous |
| ack_clr_i | input | LINES | Per-line acknowledge; releases a caught bit in catch mode |
| req_o | output | LINES | Registered request vector |
| any_o | output | 1 | OR of all bits of `req_o` |

## Verification
The case that matters is a new request reaching the capture cell in the same cycle as that line's acknowledge. It is provoked by raising a request, then asserting the clear exactly SYNC_STAGES cycles later. At that point the synchronised copy and the clear meet at one edge, and the bit must stay set. A long pseudo-random sweep then mixes requests, clears and mode changes on every line. Each cycle is compared against a cycle-level model in the bench, built from the requirements, so clears that overlap arriving requests and mode switches with bits pending are judged bit by bit.

// File: rtl/irq_capture_pkg.sv
package irq_capture_pkg;

   typedef enum logic {
      CAP_MODE_CATCH = 1'b0,
      CAP_MODE_LEVEL = 1'b1
   } cap_mode_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   import irq_capture_pkg::*;

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("irq_sync_chain: STAGES must be at least %0d", MIN_SYNC_STAGES);
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("irq_sync_chain: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk_i) begin
      if (rst_i) stage_q[0] <= '0;
      else       stage_q[0] <= async_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i) begin
         if (rst_i) stage_q[s] <= '0;
         else       stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_o = stage_q[LAST];

endmodule

// File: rtl/irq_capture_cell.sv
module irq_capture_cell
   import irq_capture_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_i,
   input  cap_mode_e mode_i,
   input  logic      req_sync_i,
   input  logic      clr_i,
   output logic      bit_o
);

   logic bit_q;
   logic catch_next;
   logic bit_next;

   always_comb begin
      catch_next = req_sync_i | (bit_q & ~clr_i);
      if (mode_i == CAP_MODE_LEVEL) bit_next = req_sync_i;
      else                          bit_next = catch_next;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) bit_q <= 1'b0;
      else       bit_q <= bit_next;
   end

   assign bit_o = bit_q;

   assert_reset_clears_R1: assert property (@(posedge clk_i)
      rst_i |=> (bit_o == 1'b0));

   assert_sticky_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i == CAP_MODE_CATCH && bit_o && !clr_i) |=> bit_o);

   assert_clear_releases_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i == CAP_MODE_CATCH && clr_i && !req_sync_i) |=> !bit_o);

   assert_set_beats_clear_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i == CAP_MODE_CATCH && req_sync_i) |=> bit_o);

   assert_level_follows_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i == CAP_MODE_LEVEL) |=> (bit_o == $past(req_sync_i)));

endmodule

// File: rtl/irq_capture_reg.sv
module irq_capture_reg
   import irq_capture_pkg::*;
#(
   parameter int unsigned LINES       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             mode_i,
   input  logic [LINES-1:0] req_i,
   input  logic [LINES-1:0] ack_clr_i,
   output logic [LINES-1:0] req_o,
   output logic             any_o
);

   if (LINES < 1) begin : g_bad_lines
      $error("irq_capture_reg: LINES must be at least 1");
   end

   cap_mode_e        mode;
   logic [LINES-1:0] req_sync;

   assign mode = cap_mode_e'(mode_i);

   irq_sync_chain #(
      .WIDTH  (LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .async_i (req_i),
      .sync_o  (req_sync)
   );

   for (genvar k = 0; k < LINES; k++) begin : g_line
      irq_capture_cell u_cell (
         .clk_i      (clk_i),
         .rst_i      (rst_i),
         .mode_i     (mode),
         .req_sync_i (req_sync[k]),
         .clr_i      (ack_clr_i[k]),
         .bit_o      (req_o[k])
      );
   end

   assign any_o = |req_o;

   assert_any_nonzero_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (any_o == 1'b0) |-> ($countones(req_o) == 0));

   assert_other_lines_kept_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode == CAP_MODE_CATCH && $countones(ack_clr_i) == 0) |=> ((req_o & $past(req_o)) == $past(req_o)));

endmodule

// File: tb/irq_capture_reg_tb.sv
module irq_capture_reg_tb;

   localparam int unsigned W          = 4;
   localparam int unsigned CLK_PERIOD = 10;

   logic         clk_i = 1'b0;
   logic         rst_i = 1'b1;
   logic         mode_i = 1'b0;
   logic [W-1:0] req_i = '0;
   logic [W-1:0] ack_clr_i = '0;
   logic [W-1:0] req_o;
   logic         any_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [W-1:0] m1 = '0, m2 = '0, mq = '0;

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   irq_capture_reg #(.LINES(W), .SYNC_STAGES(2)) u_dut (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .mode_i    (mode_i),
      .req_i     (req_i),
      .ack_clr_i (ack_clr_i),
      .req_o     (req_o),
      .any_o     (any_o)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // drive inputs at a falling edge, advance one rising edge, then compare with the model
   task automatic step(input logic r, input logic [W-1:0] rq, input logic [W-1:0] cl, input logic md);
      logic [W-1:0] nq;
      rst_i = r; req_i = rq; ack_clr_i = cl; mode_i = md;
      if (r) begin
         nq = '0; m2 = '0; m1 = '0;
      end else begin
         nq = md ? m2 : (m2 | (mq & ~cl));
         m2 = m1; m1 = rq;
      end
      @(negedge clk_i);
      mq = nq;
      check(md ? "R6 model" : "R3 model", req_o, mq);
      check("R7 any", {{(W-1){1'b0}}, any_o}, {{(W-1){1'b0}}, |mq});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk_i);
      // R1: reset with requests high
      step(1, 4'b1111, 4'b0000, 0);
      step(1, 4'b1111, 4'b0000, 0);
      check("R1 reset req_o", req_o, 4'b0000);
      check("R1 reset any_o", {3'b000, any_o}, 4'b0000);
      step(0, 4'b0000, 4'b0000, 0);
      step(0, 4'b0000, 4'b0000, 0);
      step(0, 4'b0000, 4'b0000, 0);
      // R2 and R9: one-cycle pulse on line 0
      step(0, 4'b0001, 4'b0000, 0);
      check("R2 edge1", req_o, 4'b0000);
      step(0, 4'b0000, 4'b0000, 0);
      check("R2 edge2", req_o, 4'b0000);
      step(0, 4'b0000, 4'b0000, 0);
      check("R2 edge3", req_o, 4'b0001);
      check("R9 short pulse caught", req_o, 4'b0001);
      // R3: held without clear
      for (int i = 0; i < 5; i++) step(0, 4'b0000, 4'b0000, 0);
      check("R3 sticky", req_o, 4'b0001);
      // R8: set line 1, clear only line 0
      step(0, 4'b0010, 4'b0000, 0);
      step(0, 4'b0000, 4'b0000, 0);
      step(0, 4'b0000, 4'b0000, 0);
      check("R8 two set", req_o, 4'b0011);
      step(0, 4'b0000, 4'b0001, 0);
      check("R8 line1 kept", req_o, 4'b0010);
      // R4: clear line 1
      step(0, 4'b0000, 4'b0010, 0);
      check("R4 cleared", req_o, 4'b0000);
      // R5: synced request meets clear at the same edge
      step(0, 4'b0100, 4'b0000, 0);
      step(0, 4'b0000, 4'b0000, 0);
      step(0, 4'b0000, 4'b0100, 0);
      check("R5 set wins", req_o, 4'b0100);
      step(0, 4'b0000, 4'b0100, 0);
      check("R4 later clear", req_o, 4'b0000);
      // R6: level mode, clears ignored
      for (int i = 0; i < 3; i++) step(0, 4'b1010, 4'b1111, 1);
      check("R6 level high", req_o, 4'b1010);
      step(0, 4'b0000, 4'b1111, 1);
      step(0, 4'b0000, 4'b1111, 1);
      check("R6 still high", req_o, 4'b1010);
      step(0, 4'b0000, 4'b0000, 1);
      check("R6 level low", req_o, 4'b0000);
      check("R7 idle", {3'b000, any_o}, 4'b0000);
      // sweep: random requests, clears and modes
      for (int i = 0; i < 3000; i++) begin
         logic [W-1:0] rr, cc;
         logic mm;
         rr = W'($urandom_range(0, 15));
         cc = W'($urandom_range(0, 15)) & W'($urandom_range(0, 15));
         mm = ($urandom_range(0, 7) == 0);
         if ((i % 4) != 0) rr = rr & W'($urandom_range(0, 15));
         step(0, rr, cc, mm);
      end
      // R1 again mid-run
      step(1, 4'b1111, 4'b0000, 0);
      check("R1 reset mid-run", req_o, 4'b0000);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule